// File: doc/BRIEF.md
# Configurable Down-Counting Timer Channel

This block is a single timer channel built around one decrementing counter. An external tick enable, divided by a selectable prescaler, advances the counter. Register write strobes with a shared data bus set the reload value (with or without forcing the count), the control word and the interrupt clear. The block drives the current count, the stored control word, a raw interrupt flag and an interrupt flag gated by the enable bit.

The counter can be 16 or 32 bits wide. When it passes zero it either wraps to all ones (free-running) or reloads from the stored reload value (periodic). A one-shot option stops it at zero. Bus decoding, identification registers and the merging of interrupts from several channels belong to the surrounding logic.

Top module: `down_timer_chan`

## Requirements
- R1: After reset the control word reads 0x20, the count reads 0xFFFFFFFF, the raw interrupt flag is 0, and ticks do not change the count.
- R2: A control write keeps bit 0 (one-shot), bit 1 (wide: 1 = 32-bit), bits 3:2 (prescale), bit 5 (interrupt enable), bit 6 (periodic: 1 = reload, 0 = wrap) and bit 7 (run). Bit 4 always reads zero.
- R3: A reload write stores the value as the reload value and also places it in the count on the next edge.
- R4: A background reload write changes only the reload value. The count is unchanged, and the new value is used at the next periodic reload.
- R5: While the run bit is set, the count decrements once per prescaled tick. Without a tick it holds.
- R6: Prescale code 00 gives one step per tick, 01 gives one step per 16 ticks, 10 gives one step per 256 ticks, and 11 behaves like 10. Changing the code restarts the division.
- R7: In free-running mode, a step from zero gives 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R8: In periodic mode, a step from zero loads the reload value, limited to the low 16 bits in 16-bit mode.
- R9: In 16-bit mode only count bits 15:0 change, and bits 31:16 keep their value.
- R10: The raw flag sets on the step that brings the count to zero, and a clear write resets it. The masked flag is the raw flag when bit 5 is set and 0 otherwise.
- R11: In one-shot mode the count stays at zero after it reaches zero, whatever ticks follow.
- R12: A reload write of zero in periodic mode stops counting until a later write restarts it. A nonzero reload write restarts an expired one-shot count.
- R13: A control write with bit 7 set restarts an expired one-shot count, even if bit 7 was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable, fed to the prescaler |
| ld_we | input | 1 | Reload write; also forces the count |
| bgld_we | input | 1 | Background reload write; reload value only |
| ctl_we | input | 1 | Control word write |
| iclr_we | input | 1 | Interrupt clear write |
| wdata | input | 32 | Write data for all strobes |
| count_o | output | 32 | Current count |
| ctrl_o | output | 8 | Stored control word |
| raw_irq | output | 1 | Raw interrupt flag |
| masked_irq | output | 1 | Raw flag gated by interrupt enable |

## Verification
The hardest states to reach are the halted ones: an expired one-shot count, and a periodic count stopped by a zero reload write. They look the same as an idle count sitting at zero. The bench reaches each state through its own write sequence. It then issues ticks and confirms the count stays put. Next it applies the specific restart path (a control write with the run bit, or a nonzero reload write) and confirms the following tick moves the count again. For the zero-reload case, a background reload write of a nonzero value is placed between the halt and the ticks, so a design that kept counting would show the new reload value.

// File: rtl/down_timer_chan.sv
module down_timer_chan #(
  parameter int CNT_W       = 32,
  parameter int NARROW_W    = 16,
  parameter int DIV_MID_LOG = 4,
  parameter int DIV_MAX_LOG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld_we,
  input  logic             bgld_we,
  input  logic             ctl_we,
  input  logic             iclr_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       ctrl_o,
  output logic             raw_irq,
  output logic             masked_irq
);
  localparam int PRE_W = DIV_MAX_LOG;
  localparam logic [7:0] CTRL_KEEP = 8'hEF;
  localparam logic [7:0] CTRL_RST  = 8'h20;
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [PRE_W-1:0] MID_LIM = PRE_W'((1 << DIV_MID_LOG) - 1);

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             raw_q, halt_q;

  wire one_shot = ctrl_q[0];
  wire wide     = ctrl_q[1];
  wire periodic = ctrl_q[6];
  wire run      = ctrl_q[7];

  always_comb begin
    case (ctrl_q[3:2])
      2'b00:   pre_lim = '0;
      2'b01:   pre_lim = MID_LIM;
      default: pre_lim = '1;
    endcase
  end

  wire [CNT_W-1:0] live_mask = wide ? {CNT_W{1'b1}} : NARROW_MASK;
  wire             active    = run & ~halt_q;
  wire             step      = tick_en & active & (pre_q == pre_lim) & ~ld_we;
  wire             at_zero   = (cnt_q & live_mask) == '0;
  wire             at_one    = (cnt_q & live_mask) == CNT_W'(1);
  wire [CNT_W-1:0] wrap_val  = periodic ? reload_q : {CNT_W{1'b1}};
  wire [CNT_W-1:0] low_next  = at_zero ? wrap_val : cnt_q - 1'b1;
  wire [CNT_W-1:0] cnt_next  = (cnt_q & ~live_mask) | (low_next & live_mask);
  wire             ld_halts  = periodic & ((wdata & live_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= '0;
      cnt_q    <= '1;
      raw_q    <= 1'b0;
      halt_q   <= 1'b0;
      pre_q    <= '0;
    end else begin
      if (ctl_we)
        ctrl_q <= wdata[7:0] & CTRL_KEEP;

      if (ctl_we && (wdata[3:2] != ctrl_q[3:2]))
        pre_q <= '0;
      else if (tick_en && active)
        pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;

      if (ld_we || bgld_we)
        reload_q <= wdata;

      if (ld_we)
        cnt_q <= wdata;
      else if (step)
        cnt_q <= cnt_next;

      if (step && at_one)
        raw_q <= 1'b1;
      else if (iclr_we)
        raw_q <= 1'b0;

      if (ld_we)
        halt_q <= ld_halts;
      else if (ctl_we && wdata[7])
        halt_q <= 1'b0;
      else if (step && at_one && one_shot)
        halt_q <= 1'b1;
    end
  end

  assign count_o    = cnt_q;
  assign ctrl_o     = ctrl_q;
  assign raw_irq    = raw_q;
  assign masked_irq = raw_q & ctrl_q[5];
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ld_we,
  input logic             bgld_we,
  input logic             ctl_we,
  input logic             iclr_we,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] count_o,
  input logic [7:0]       ctrl_o,
  input logic             raw_irq
);
  p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctrl_o == ($past(wdata[7:0]) & 8'hEF));

  p_load_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> count_o == $past(wdata));

  p_bg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bgld_we && !ld_we && !tick_en) |=> $stable(count_o));

  p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_we) |=> $stable(count_o));

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr_we && !tick_en) |=> !raw_irq);

  p_rise_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(raw_irq) && !$past(ctl_we)) |->
      (ctrl_o[1] ? (count_o == '0) : (count_o[NARROW_W-1:0] == '0)));
endmodule

bind down_timer_chan timer_chan_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_we(ld_we), .bgld_we(bgld_we),
  .ctl_we(ctl_we), .iclr_we(iclr_we), .wdata(wdata), .count_o(count_o),
  .ctrl_o(ctrl_o), .raw_irq(raw_irq)
);

// File: tb/sim_down_timer_chan.sv
`timescale 1ns/1ps
module sim_down_timer_chan;
  localparam logic [31:0] ONE = 32'h01, WIDE = 32'h02, PS16 = 32'h04, PS256 = 32'h08,
                          PS11 = 32'h0C, IE = 32'h20, PER = 32'h40, EN = 32'h80;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic ld_we = 1'b0, bgld_we = 1'b0, ctl_we = 1'b0, iclr_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] count_o;
  logic [7:0]  ctrl_o;
  logic raw_irq, masked_irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  down_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_we(ld_we), .bgld_we(bgld_we),
    .ctl_we(ctl_we), .iclr_we(iclr_we), .wdata(wdata), .count_o(count_o),
    .ctrl_o(ctrl_o), .raw_irq(raw_irq), .masked_irq(masked_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input logic [31:0] v);
    @(negedge clk);
    wdata = v;
    case (kind)
      0: ld_we = 1'b1;
      1: bgld_we = 1'b1;
      2: ctl_we = 1'b1;
      default: iclr_we = 1'b1;
    endcase
    @(negedge clk);
    ld_we = 1'b0; bgld_we = 1'b0; ctl_we = 1'b0; iclr_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", {24'h0, ctrl_o}, 32'h20);
    chk("R1 count", count_o, 32'hFFFF_FFFF);
    chk("R1 raw", {31'h0, raw_irq}, 0);
    ticks(5);
    chk("R1 stopped", count_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl;
    wr(2, 32'hFFFF_FF7F);
    chk("R2 mask", {24'h0, ctrl_o}, 32'h6F);
    wr(2, IE);
    chk("R2 plain", {24'h0, ctrl_o}, 32'h20);
  endtask

  task automatic t_load;
    wr(0, 32'h1234_0005);
    chk("R3 load", count_o, 32'h1234_0005);
  endtask

  task automatic t_free16;
    wr(2, EN | IE);
    ticks(4);
    chk("R5 dec", count_o, 32'h1234_0001);
    chk("R10 not yet", {31'h0, raw_irq}, 0);
    ticks(1);
    chk("R10 zero", count_o, 32'h1234_0000);
    chk("R10 raw", {31'h0, raw_irq}, 1);
    chk("R10 masked", {31'h0, masked_irq}, 1);
    ticks(1);
    chk("R7 R9 wrap16", count_o, 32'h1234_FFFF);
    wr(3, 0);
    chk("R10 clr", {31'h0, raw_irq}, 0);
    wr(0, 1);
    ticks(1);
    wr(2, EN);
    chk("R10 raw kept", {31'h0, raw_irq}, 1);
    chk("R10 gated", {31'h0, masked_irq}, 0);
    wr(2, EN | IE);
    chk("R10 ungated", {31'h0, masked_irq}, 1);
    wr(3, 0);
  endtask

  task automatic t_free32;
    wr(2, 0);
    wr(0, 1);
    wr(2, EN | WIDE);
    ticks(2);
    chk("R7 wrap32", count_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_periodic;
    wr(2, 0);
    wr(0, 3);
    wr(2, EN | PER | WIDE);
    ticks(3);
    chk("R8 zero", count_o, 0);
    ticks(1);
    chk("R8 reload", count_o, 3);
    wr(1, 7);
    chk("R4 count kept", count_o, 3);
    ticks(4);
    chk("R4 bg used", count_o, 7);
    wr(2, 0);
    wr(0, 32'hABCD_0002);
    wr(2, EN | PER);
    wr(1, 32'h5555_0004);
    ticks(2);
    chk("R9 upper kept", count_o, 32'hABCD_0000);
    ticks(1);
    chk("R8 R9 narrow reload", count_o, 32'hABCD_0004);
  endtask

  task automatic t_prescale;
    wr(2, 0);
    wr(0, 10);
    wr(2, EN | WIDE | PS16);
    ticks(15);
    chk("R6 div16 wait", count_o, 10);
    ticks(1);
    chk("R6 div16 step", count_o, 9);
    wr(2, EN | WIDE | PS256);
    ticks(255);
    chk("R6 div256 wait", count_o, 9);
    ticks(1);
    chk("R6 div256 step", count_o, 8);
    wr(2, EN | WIDE | PS11);
    ticks(255);
    chk("R6 code11 wait", count_o, 8);
    ticks(1);
    chk("R6 code11 step", count_o, 7);
    wr(2, EN | WIDE);
    ticks(1);
    chk("R6 div1", count_o, 6);
  endtask

  task automatic t_oneshot;
    wr(2, 0);
    wr(0, 2);
    wr(2, EN | WIDE | ONE | IE);
    ticks(2);
    chk("R11 zero", count_o, 0);
    chk("R11 raw", {31'h0, raw_irq}, 1);
    ticks(5);
    chk("R11 held", count_o, 0);
    wr(3, 0);
    wr(2, EN | WIDE | IE);
    ticks(1);
    chk("R13 restart", count_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_ld_restart;
    wr(2, EN | WIDE | ONE);
    wr(0, 2);
    ticks(4);
    chk("R11 stop", count_o, 0);
    wr(0, 3);
    ticks(1);
    chk("R12 nonzero restart", count_o, 2);
    wr(2, EN | WIDE | PER);
    wr(0, 0);
    wr(1, 5);
    ticks(3);
    chk("R12 zero halts", count_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_load();
    t_free16();
    t_free32();
    t_periodic();
    t_prescale();
    t_oneshot();
    t_ld_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule